// File: doc/BRIEF.md
# Jitter Attenuator Elastic Buffer

This block smooths a bit stream whose arrivals are jittery, gapped or bursty. Incoming bits come with a single-cycle write strobe in a fast reference clock domain that runs at sixteen times the nominal line rate. A divider on that same reference clock paces the reads. Each time the divider reaches its terminal count, one bit leaves the buffer. The output pacing therefore stays evenly spaced even when the writes arrive in clumps.

The divider normally counts sixteen reference cycles per output bit. When the fill level comes close to either edge of the active depth, one interval is shortened to fifteen cycles to drain the buffer, or lengthened to seventeen cycles to let it refill. Each such stretched or shrunk interval sets a sticky limit-trip flag. The active depth can be chosen between a short, low-delay setting and a long, wander-tolerant setting. A strap input can force the long setting. A bypass input removes the buffer from the path altogether.

Top module: `jitter_elastic_buf`

## Requirements
- R1: After reset, the active depth is DEPTH_LO when `depth_sel`=0 and DEPTH_HI when `depth_sel`=1. The buffer then holds half the active depth of zero bits, `fill_level` shows that half-depth value, and `out_valid`, `limit_trip`, `ovf_flag` and `unf_flag` are all 0.
- R2: While `depth_fixed`=1, the active depth is DEPTH_HI and `depth_sel` has no effect. Toggling it neither recentres nor changes `fill_level`.
- R3: `out_valid` is a one-cycle pulse. The first pulse follows the NOM_DIV-th rising edge after reset is released. While the fill level lies within the thresholds, successive pulses are NOM_DIV cycles apart.
- R4: An interval is chosen from the fill level at the moment it starts. If the fill level is above (depth − MARGIN), the interval is NOM_DIV−1 cycles. If it is below MARGIN, the interval is NOM_DIV+1 cycles.
- R5: `limit_trip` goes to 1 on every read whose interval was NOM_DIV−1 or NOM_DIV+1. It stays at 1 until a `status_clr` pulse clears it. If a new trip and a clear occur in the same cycle, the trip wins.
- R6: While `bypass`=1, `out_bit` equals `in_bit` and `out_valid` equals `in_stb` in the same cycle, with no register between them. `fill_level` does not change and no trip is recorded.
- R7: The spacing of `out_valid` pulses stays between NOM_DIV−1 and NOM_DIV+1 cycles whatever the pattern of writes, including gapped and bursty strobes.
- R8: When the active depth changes, the buffer is recentred on that edge, so `fill_level` becomes half the new depth. Any write or read in that cycle is dropped, and no `out_valid` pulse is produced.
- R9: A write while the buffer is full, with no read in the same cycle, discards the oldest bit and keeps `fill_level` at the depth. It also sets the sticky `ovf_flag`, which only `status_clr` clears.
- R10: A read while the buffer is empty produces an `out_valid` pulse that repeats the previous `out_bit` and leaves `fill_level` unchanged apart from any same-cycle write. It also sets the sticky `unf_flag`, which only `status_clr` clears.
- R11: Bits leave in arrival order. `out_bit` and `fill_level` update on the same reference edge that raises `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, sixteen times the line rate |
| rst_n | input | 1 | Active-low synchronous reset |
| in_stb | input | 1 | Write strobe, one cycle per incoming bit |
| in_bit | input | 1 | Incoming data bit |
| depth_sel | input | 1 | 0 = DEPTH_LO, 1 = DEPTH_HI |
| depth_fixed | input | 1 | Strap that forces DEPTH_HI |
| bypass | input | 1 | Removes the buffer from the path |
| status_clr | input | 1 | Clears the sticky flags |
| out_bit | output | 1 | Smoothed output bit |
| out_valid | output | 1 | One-cycle pulse per output bit |
| fill_level | output | $clog2(DEPTH_HI+1) | Bits currently held |
| limit_trip | output | 1 | Sticky flag for divide-by-15/17 intervals |
| ovf_flag | output | 1 | Sticky overflow flag |
| unf_flag | output | 1 | Sticky underflow flag |

## Verification
The bench builds the block with DEPTH_LO=8, DEPTH_HI=16, NOM_DIV=16 and MARGIN=4. With these values, the short depth has a single nominal fill value, so both correction ratios and both flag conditions appear within a few hundred cycles. A depth change from 8 to 16 and back is short enough to check the recentring and the strap override directly. Keeping NOM_DIV at its real value of 16 means the pulse spacing seen by the bench is the true 15/16/17 pattern.

// File: rtl/jeb_pkg.sv
package jeb_pkg;

  // Active buffer depth from the select bit and the strap.
  function automatic int depth_for(input logic sel, input logic strap,
                                   input int lo, input int hi);
    return (strap || sel) ? hi : lo;
  endfunction

  // Read interval chosen from the fill level at the start of the interval.
  function automatic int ratio_for(input int fill, input int depth,
                                   input int margin, input int nom);
    if (fill > depth - margin) return nom - 1;
    if (fill < margin)         return nom + 1;
    return nom;
  endfunction

endpackage

// File: rtl/jeb_rate_div.sv
module jeb_rate_div #(
  parameter int NOM_DIV = 16,
  parameter int CW      = $clog2(NOM_DIV + 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] ratio,
  output logic          tick
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] gap_q;

  assign tick = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= CW'(NOM_DIV - 1);
      gap_q <= '0;
    end else begin
      cnt_q <= tick ? ratio - CW'(1) : cnt_q - CW'(1);
      gap_q <= tick ? '0 : gap_q + CW'(1);
    end
  end

  // The gap between ticks is NOM-1 .. NOM+1 cycles.
  assert_tick_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> (gap_q >= CW'(NOM_DIV - 2)) && (gap_q <= CW'(NOM_DIV)));

endmodule

// File: rtl/jeb_fifo.sv
module jeb_fifo #(
  parameter int DEPTH_HI = 128,
  parameter int PW       = $clog2(DEPTH_HI),
  parameter int FW       = $clog2(DEPTH_HI + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [FW-1:0] depth,
  input  logic          recentre,
  input  logic          wr_en,
  input  logic          wr_bit,
  input  logic          rd_en,
  output logic          rd_bit,
  output logic          rd_pulse,
  output logic [FW-1:0] fill,
  output logic          ovf_evt,
  output logic          unf_evt
);
  logic [DEPTH_HI-1:0] mem_q;
  logic [PW-1:0]       wr_ptr_q, rd_ptr_q;
  logic [FW-1:0]       fill_q;
  logic                bit_q, pulse_q;
  logic                empty, full, do_rd;
  logic [PW-1:0]       half;

  assign half    = PW'(depth >> 1);
  assign empty   = (fill_q == '0);
  assign full    = (fill_q == depth);
  assign do_rd   = rd_en && !empty;
  assign ovf_evt = wr_en && !rd_en && full;
  assign unf_evt = rd_en && empty;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_q    <= '0;
      wr_ptr_q <= '0;
      rd_ptr_q <= PW'(0) - half;
      fill_q   <= depth >> 1;
      bit_q    <= 1'b0;
      pulse_q  <= 1'b0;
    end else if (recentre) begin
      rd_ptr_q <= wr_ptr_q - half;
      fill_q   <= depth >> 1;
      pulse_q  <= 1'b0;
    end else begin
      pulse_q <= rd_en;
      if (do_rd) bit_q <= mem_q[rd_ptr_q];
      if (wr_en) begin
        mem_q[wr_ptr_q] <= wr_bit;
        wr_ptr_q        <= wr_ptr_q + PW'(1);
      end
      if (do_rd || ovf_evt) rd_ptr_q <= rd_ptr_q + PW'(1);
      fill_q <= fill_q + FW'(wr_en && !ovf_evt) - FW'(do_rd);
    end
  end

  assign rd_bit   = bit_q;
  assign rd_pulse = pulse_q;
  assign fill     = fill_q;

  assert_fill_cap_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !recentre |-> fill_q <= depth);
  assert_ovf_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> fill_q == $past(fill_q));
  assert_unf_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    unf_evt |=> fill_q <= FW'(1));

endmodule

// File: rtl/jitter_elastic_buf.sv
module jitter_elastic_buf
  import jeb_pkg::*;
#(
  parameter int DEPTH_LO = 32,
  parameter int DEPTH_HI = 128,
  parameter int NOM_DIV  = 16,
  parameter int MARGIN   = 4,
  localparam int FW      = $clog2(DEPTH_HI + 1),
  localparam int PW      = $clog2(DEPTH_HI),
  localparam int CW      = $clog2(NOM_DIV + 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_stb,
  input  logic          in_bit,
  input  logic          depth_sel,
  input  logic          depth_fixed,
  input  logic          bypass,
  input  logic          status_clr,
  output logic          out_bit,
  output logic          out_valid,
  output logic [FW-1:0] fill_level,
  output logic          limit_trip,
  output logic          ovf_flag,
  output logic          unf_flag
);
  logic [FW-1:0] depth_now, depth_q;
  logic          depth_chg;
  logic [CW-1:0] ratio;
  logic          tick, rd_en, wr_en, trip_evt;
  logic          rd_bit, rd_pulse, ovf_evt, unf_evt;
  logic          trip_q, ovf_q, unf_q;

  assign depth_now = FW'(depth_for(depth_sel, depth_fixed, DEPTH_LO, DEPTH_HI));
  assign depth_chg = (depth_now != depth_q);
  assign ratio     = CW'(ratio_for(int'(fill_level), int'(depth_q), MARGIN, NOM_DIV));

  jeb_rate_div #(.NOM_DIV(NOM_DIV), .CW(CW)) u_div (
    .clk(clk), .rst_n(rst_n), .ratio(ratio), .tick(tick)
  );

  assign rd_en    = tick && !bypass && !depth_chg;
  assign wr_en    = in_stb && !bypass && !depth_chg;
  assign trip_evt = rd_en && (ratio != CW'(NOM_DIV));

  jeb_fifo #(.DEPTH_HI(DEPTH_HI), .PW(PW), .FW(FW)) u_fifo (
    .clk(clk), .rst_n(rst_n), .depth(depth_now), .recentre(depth_chg),
    .wr_en(wr_en), .wr_bit(in_bit), .rd_en(rd_en),
    .rd_bit(rd_bit), .rd_pulse(rd_pulse), .fill(fill_level),
    .ovf_evt(ovf_evt), .unf_evt(unf_evt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      depth_q <= depth_now;
      trip_q  <= 1'b0;
      ovf_q   <= 1'b0;
      unf_q   <= 1'b0;
    end else begin
      depth_q <= depth_now;
      trip_q  <= (trip_q && !status_clr) || trip_evt;
      ovf_q   <= (ovf_q  && !status_clr) || ovf_evt;
      unf_q   <= (unf_q  && !status_clr) || unf_evt;
    end
  end

  assign limit_trip = trip_q;
  assign ovf_flag   = ovf_q;
  assign unf_flag   = unf_q;
  assign out_bit    = bypass ? in_bit : rd_bit;
  assign out_valid  = bypass ? in_stb : rd_pulse;

  assert_trip_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    limit_trip && !status_clr |=> limit_trip);
  assert_recentre_R8: assert property (@(posedge clk) disable iff (!rst_n)
    depth_chg |=> fill_level == ($past(depth_now) >> 1));
  assert_bypass_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bypass && !depth_chg |=> fill_level == $past(fill_level));
  assert_pulse_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!bypass && out_valid) |=> !(out_valid && !bypass && !$past(bypass)));

endmodule

// File: tb/tb_jitter_elastic_buf.sv
module tb_jitter_elastic_buf;
  localparam int LO = 8, HI = 16, NOM = 16, MG = 4;
  localparam int FW = $clog2(HI + 1);

  logic clk = 0, rst_n = 0;
  logic s_stb = 0, s_bit = 0, s_sel = 0, s_fix = 0, s_byp = 0, s_clr = 0;
  logic out_bit, out_valid, limit_trip, ovf_flag, unf_flag;
  logic [FW-1:0] fill_level;

  jitter_elastic_buf #(.DEPTH_LO(LO), .DEPTH_HI(HI), .NOM_DIV(NOM), .MARGIN(MG)) dut (
    .clk(clk), .rst_n(rst_n), .in_stb(s_stb), .in_bit(s_bit), .depth_sel(s_sel),
    .depth_fixed(s_fix), .bypass(s_byp), .status_clr(s_clr), .out_bit(out_bit),
    .out_valid(out_valid), .fill_level(fill_level), .limit_trip(limit_trip),
    .ovf_flag(ovf_flag), .unf_flag(unf_flag)
  );

  always #10 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0, last_v = 0, last_iv = 0;
  bit spacing_on = 0, done = 0;
  // reference model state; 2 marks a bit of unknown value
  int q[$];
  int m_cnt, m_d, m_v, m_b, m_trip, m_ovf, m_unf;

  function automatic int depth_of(bit sel, bit fix);
    return (sel || fix) ? HI : LO;
  endfunction
  function automatic int interval_of(int f, int d);
    if (f > d - MG) return NOM - 1;
    if (f < MG) return NOM + 1;
    return NOM;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_reset();
    q.delete();
    m_d = depth_of(s_sel, s_fix);
    for (int i = 0; i < m_d / 2; i++) q.push_back(0);
    m_cnt = NOM - 1; m_v = 0; m_b = 0; m_trip = 0; m_ovf = 0; m_unf = 0;
  endtask

  task automatic model_step();
    int dn, f, r, ts, os, us;
    bit tk;
    dn = depth_of(s_sel, s_fix);
    f = q.size(); tk = (m_cnt == 0); r = interval_of(f, m_d);
    m_cnt = tk ? r - 1 : m_cnt - 1;
    ts = 0; os = 0; us = 0;
    if (dn != m_d) begin
      q.delete();
      for (int i = 0; i < dn / 2; i++) q.push_back(2);
      m_d = dn; m_v = 0;
    end else if (s_byp) begin
      m_v = 0;
    end else begin
      m_v = tk;
      if (tk) begin
        if (f == 0) us = 1; else m_b = q.pop_front();
        if (r != NOM) ts = 1;
      end
      if (s_stb) begin
        if (q.size() == m_d && !tk) begin void'(q.pop_front()); os = 1; end
        q.push_back(int'(s_bit));
      end
    end
    m_trip = (m_trip && !s_clr) || ts;
    m_ovf  = (m_ovf && !s_clr) || os;
    m_unf  = (m_unf && !s_clr) || us;
  endtask

  task automatic compare();
    chk(int'(fill_level) == q.size(), "R11 fill", int'(fill_level), q.size());
    chk(limit_trip == m_trip, "R5 trip", limit_trip, m_trip);
    chk(ovf_flag == m_ovf, "R9 ovf", ovf_flag, m_ovf);
    chk(unf_flag == m_unf, "R10 unf", unf_flag, m_unf);
    if (!s_byp) begin
      chk(out_valid == m_v, "R3 valid", out_valid, m_v);
      if (m_v && m_b != 2) chk(int'(out_bit) == m_b, "R11 bit", out_bit, m_b);
      if (out_valid) begin
        if (spacing_on && last_v > 0) begin
          last_iv = cyc - last_v;
          chk(last_iv >= NOM - 1 && last_iv <= NOM + 1, "R7 spacing", last_iv, NOM);
        end
        last_v = cyc;
      end
    end
  endtask

  // we are at a negedge: apply inputs, predict, advance to next negedge, compare
  task automatic step(bit w, bit b);
    s_stb = w; s_bit = b;
    model_step();
    @(negedge clk); cyc++;
    compare();
    s_clr = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    finish_run();
  end

  initial begin
    int f0;
    void'($urandom(32'd7741));
    repeat (3) @(negedge clk);
    rst_n = 1; model_reset();
    // R1 reset state, depth LO
    chk(int'(fill_level) == LO / 2, "R1 reset fill", int'(fill_level), LO / 2);
    chk(!out_valid && !limit_trip && !ovf_flag && !unf_flag, "R1 reset flags", 1, 0);
    // R3 first pulse after NOM edges
    idle(NOM - 1);
    chk(!out_valid, "R3 no early pulse", out_valid, 0);
    step(0, 0);
    chk(out_valid && out_bit == 0, "R3 first pulse", out_valid, 1);
    last_v = cyc; spacing_on = 1;
    // random writes near line rate
    for (int i = 0; i < 1500; i++) step(($urandom % 16) == 0, $urandom % 2);
    // gapped bursts
    for (int i = 0; i < 25; i++) begin
      for (int k = 0; k < 4; k++) step(1, $urandom % 2);
      idle(60);
    end
    // R5 clear
    s_clr = 1; step(0, 0);
    // R9 overflow and R4 fast interval
    for (int i = 0; i < 80; i++) step(1, $urandom % 2);
    chk(ovf_flag == 1, "R9 ovf set", ovf_flag, 1);
    chk(last_iv == NOM - 1, "R4 fast interval", last_iv, NOM - 1);
    chk(int'(fill_level) == LO, "R9 full level", int'(fill_level), LO);
    // R10 underflow and R4 slow interval
    idle(300);
    chk(unf_flag == 1 && fill_level == 0, "R10 unf set", unf_flag, 1);
    chk(last_iv == NOM + 1, "R4 slow interval", last_iv, NOM + 1);
    s_clr = 1; step(0, 0);
    chk(!limit_trip && !ovf_flag && !unf_flag, "R5 cleared", limit_trip, 0);
    // R8 depth change to HI
    spacing_on = 0;
    s_sel = 1; step(1, 1);
    chk(int'(fill_level) == HI / 2, "R8 recentre", int'(fill_level), HI / 2);
    for (int i = 0; i < 800; i++) step(($urandom % 16) == 0, $urandom % 2);
    // R2 strap forces HI, select ignored
    s_fix = 1; step(0, 0);
    f0 = int'(fill_level);
    s_sel = 0; step(0, 0);
    chk(int'(fill_level) >= f0 - 1 && int'(fill_level) <= f0, "R2 no recentre", int'(fill_level), f0);
    for (int i = 0; i < 200; i++) step(($urandom % 16) == 0, $urandom % 2);
    // R6 bypass
    s_byp = 1; step(0, 0);
    f0 = int'(fill_level);
    for (int i = 0; i < 40; i++) begin
      s_stb = $urandom % 2; s_bit = $urandom % 2; #1;
      chk(out_bit == s_bit && out_valid == s_stb, "R6 passthrough", out_bit, s_bit);
      step(s_stb, s_bit);
    end
    chk(int'(fill_level) == f0, "R6 fill held", int'(fill_level), f0);
    s_byp = 0; step(0, 0);
    // R8 back to LO
    s_fix = 0; step(0, 0);
    chk(int'(fill_level) == LO / 2, "R8 recentre LO", int'(fill_level), LO / 2);
    for (int i = 0; i < 400; i++) step(($urandom % 16) == 0, $urandom % 2);
    finish_run();
  end
endmodule